// File: doc/BRIEF.md
# Lane-Preserving Thread Compactor

This block takes the active mask of a whole thread block and turns it into the shortest run of warps that covers every active thread. The block has `LANES * ROWS` threads. Thread `t` (zero-based) has home lane `t mod LANES` and belongs to static warp row `t / LANES`. A thread is only ever placed in its home lane, so the compacted warps need no crossing between register-file lanes. Each lane has its own priority encoder. Every cycle, each encoder takes the lowest-numbered thread of its lane that is still pending. Those picks together form one warp, and the threads picked are cleared from the pending copy of the mask.

Control is a two-state machine. In `ST_IDLE`, a `start_i` pulse loads `mask_i` into the pending register and takes the transition *accept* to `ST_EMIT`. In `ST_EMIT`, the transition *emit* stays in `ST_EMIT` for as long as pending threads remain, and one warp leaves on each such cycle. When the pending mask is empty, `done_o` pulses for one cycle and the transition *finish* returns the machine to `ST_IDLE`. The stack that produces the mask and the issue of the warps both lie outside this block.

Top module: `tc_compactor`

## Requirements
- R1: After reset, `busy_o`, `warp_valid_o` and `done_o` are low, and all slot outputs are zero.
- R2: A `start_i` pulse accepted in idle gives either `warp_valid_o` or `done_o` in the very next cycle.
- R3: A valid slot in lane `l` carries a thread ID `t` with `t mod LANES == l`. Only threads whose mask bit `t` was set appear.
- R4: Within a lane, thread IDs are emitted in strictly increasing order, lowest ID first.
- R5: Every active thread appears exactly once over the run.
- R6: Warps come out on consecutive cycles. Their number equals the largest count of active threads in any one lane. A single-cycle `done_o` follows the last warp.
- R7: An all-zero mask raises `done_o` in the cycle after start and emits no warp.
- R8: A full mask reproduces the static warps in order: warp `k` holds threads `k*LANES + l` in lane `l`.
- R9: `start_i` while `busy_o` is high (including the `done_o` cycle) is ignored.
- R10: `done_o` and `warp_valid_o` are never high together. A valid warp has at least one valid slot, and empty slots carry ID 0 and valid 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start compaction of `mask_i` (taken only when idle) |
| mask_i | input | LANES*ROWS | Active mask; bit t is thread t |
| busy_o | output | 1 | Machine is in `ST_EMIT` |
| warp_valid_o | output | 1 | A compacted warp is on the slot outputs |
| slot_vld_o | output | LANES | Per-lane slot valid |
| slot_tid_o | output | LANES*TIDW | Per-lane thread ID, lane l at bits [l*TIDW +: TIDW] |
| done_o | output | 1 | One-cycle pulse: all threads emitted |

## Verification
The bench builds the block with four lanes and three rows. At that size, all 4096 masks can be swept in order, which covers every per-lane occupancy pattern from empty to a full column, together with the all-zero and all-one masks. A start pulse issued in the middle of a run, and another in the cycle that carries `done_o`, check that a busy machine drops the request.

// File: rtl/tc_pkg.sv
package tc_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } tc_state_e;
endpackage

// File: rtl/tc_lane_pick.sv
// Priority encoder for one lane: lowest pending row wins.
module tc_lane_pick #(
    parameter int ROWS = 3,
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic [ROWS-1:0] bits_i,
    output logic            hit_o,
    output logic [RW-1:0]   row_o,
    output logic [ROWS-1:0] take_o
);
    always_comb begin
        row_o = '0;
        for (int r = ROWS - 1; r >= 0; r--) begin
            if (bits_i[r]) row_o = RW'(r);
        end
        hit_o  = |bits_i;
        take_o = hit_o ? (ROWS'(1) << row_o) : '0;
    end
endmodule

// File: rtl/tc_pending.sv
// Pending copy of the active mask; loaded on accept, thinned on emit.
module tc_pending #(
    parameter int THREADS = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [THREADS-1:0] load_val_i,
    input  logic [THREADS-1:0] clear_i,
    output logic [THREADS-1:0] pend_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pend_o <= '0;
        else if (load_i) pend_o <= load_val_i;
        else             pend_o <= pend_o & ~clear_i;
    end
endmodule

// File: rtl/tc_compactor.sv
module tc_compactor #(
    parameter int LANES = 4,
    parameter int ROWS  = 3,
    localparam int THREADS = LANES * ROWS,
    localparam int TIDW    = (THREADS > 1) ? $clog2(THREADS) : 1,
    localparam int RW      = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [THREADS-1:0]    mask_i,
    output logic                  busy_o,
    output logic                  warp_valid_o,
    output logic [LANES-1:0]      slot_vld_o,
    output logic [LANES*TIDW-1:0] slot_tid_o,
    output logic                  done_o
);
    import tc_pkg::*;

    tc_state_e              state_q, state_d;
    logic [THREADS-1:0]     pend;
    logic [THREADS-1:0]     take_all;
    logic [THREADS-1:0]     clear;
    logic [LANES-1:0]       lane_hit;
    logic [LANES*TIDW-1:0]  lane_tid;
    logic                   any_pend;
    logic                   load;
    logic                   emit;

    // One encoder per lane over that lane's column of the mask.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [ROWS-1:0] col;
        logic [ROWS-1:0] take;
        logic [RW-1:0]   row;
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            assign col[r]                = pend[r*LANES + l];
            assign take_all[r*LANES + l] = take[r];
        end
        tc_lane_pick #(.ROWS(ROWS)) u_pick (
            .bits_i (col),
            .hit_o  (lane_hit[l]),
            .row_o  (row),
            .take_o (take)
        );
        assign lane_tid[l*TIDW +: TIDW] = TIDW'(row) * TIDW'(LANES) + TIDW'(l);
    end

    assign any_pend = |pend;
    assign clear    = emit ? take_all : '0;

    tc_pending #(.THREADS(THREADS)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (mask_i),
        .clear_i    (clear),
        .pend_o     (pend)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state: accept, emit, finish
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)   state_d = ST_EMIT;
            ST_EMIT: if (!any_pend) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load         = 1'b0;
        emit         = 1'b0;
        busy_o       = 1'b0;
        done_o       = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start_i;
            ST_EMIT: begin
                busy_o = 1'b1;
                emit   = any_pend;
                done_o = !any_pend;
            end
            default: ;
        endcase
        warp_valid_o = emit;
        slot_vld_o   = emit ? lane_hit : '0;
        for (int l = 0; l < LANES; l++) begin
            slot_tid_o[l*TIDW +: TIDW] = slot_vld_o[l] ? lane_tid[l*TIDW +: TIDW] : '0;
        end
    end
endmodule

// File: rtl/tc_compactor_chk.sv
module tc_compactor_chk #(
    parameter int LANES = 4,
    parameter int ROWS  = 3,
    localparam int THREADS = LANES * ROWS,
    localparam int TIDW    = (THREADS > 1) ? $clog2(THREADS) : 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start_i,
    input logic [THREADS-1:0]    mask_i,
    input logic                  busy_o,
    input logic                  warp_valid_o,
    input logic [LANES-1:0]      slot_vld_o,
    input logic [LANES*TIDW-1:0] slot_tid_o,
    input logic                  done_o
);
    AST_DONE_NOT_WITH_WARP: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && warp_valid_o)); // R10
    AST_WARP_HAS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        warp_valid_o |-> (slot_vld_o != '0)); // R10
    AST_NO_SLOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !warp_valid_o |-> (slot_vld_o == '0)); // R3
    AST_START_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (warp_valid_o || done_o)); // R2
    AST_ZERO_MASK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && mask_i == '0) |=> done_o); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o); // R9

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        AST_HOME_LANE: assert property (@(posedge clk) disable iff (!rst_n)
            slot_vld_o[l] |-> (int'(slot_tid_o[l*TIDW +: TIDW]) % LANES == l)); // R3
        AST_LANE_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
            (warp_valid_o && slot_vld_o[l] && $past(warp_valid_o) && $past(slot_vld_o[l]))
            |-> (slot_tid_o[l*TIDW +: TIDW] > $past(slot_tid_o[l*TIDW +: TIDW]))); // R4
    end
endmodule

bind tc_compactor tc_compactor_chk #(.LANES(LANES), .ROWS(ROWS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .mask_i       (mask_i),
    .busy_o       (busy_o),
    .warp_valid_o (warp_valid_o),
    .slot_vld_o   (slot_vld_o),
    .slot_tid_o   (slot_tid_o),
    .done_o       (done_o)
);

// File: tb/test_tc_compactor.sv
module test_tc_compactor;
    localparam int LANES      = 4;
    localparam int ROWS       = 3;
    localparam int THREADS    = LANES * ROWS;
    localparam int TIDW       = $clog2(THREADS);
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  start_i = 1'b0;
    logic [THREADS-1:0]    mask_i = '0;
    logic                  busy_o, warp_valid_o, done_o;
    logic [LANES-1:0]      slot_vld_o;
    logic [LANES*TIDW-1:0] slot_tid_o;

    tc_compactor #(.LANES(LANES), .ROWS(ROWS)) i_tc_compactor (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mask_i(mask_i),
        .busy_o(busy_o), .warp_valid_o(warp_valid_o), .slot_vld_o(slot_vld_o),
        .slot_tid_o(slot_tid_o), .done_o(done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // reference model state
    bit                    m_busy = 0;
    logic [LANES-1:0]      q_vld[$];
    logic [LANES*TIDW-1:0] q_tid[$];

    // per-run tallies from the ports
    int  seen[THREADS];
    int  warps_seen, dones_seen, lane_err, excl_err;
    bit  expect_first;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic build(input logic [THREADS-1:0] m);
        logic [LANES-1:0]      v[ROWS];
        logic [LANES*TIDW-1:0] t[ROWS];
        int maxc = 0;
        for (int k = 0; k < ROWS; k++) begin v[k] = '0; t[k] = '0; end
        for (int l = 0; l < LANES; l++) begin
            int c = 0;
            for (int r = 0; r < ROWS; r++) begin
                if (m[r*LANES + l]) begin
                    v[c][l] = 1'b1;
                    t[c][l*TIDW +: TIDW] = TIDW'(r*LANES + l);
                    c++;
                end
            end
            if (c > maxc) maxc = c;
        end
        for (int k = 0; k < maxc; k++) begin
            q_vld.push_back(v[k]);
            q_tid.push_back(t[k]);
        end
    endtask

    task automatic compare(input string tag);
        bit e_valid = m_busy && (q_vld.size() > 0);
        bit e_done  = m_busy && (q_vld.size() == 0);
        logic [LANES-1:0]      e_v = e_valid ? q_vld[0] : '0;
        logic [LANES*TIDW-1:0] e_t = e_valid ? q_tid[0] : '0;
        longint act = {busy_o, warp_valid_o, done_o, slot_vld_o, slot_tid_o};
        longint exp = {m_busy, e_valid, e_done, e_v, e_t};
        check(act == exp, tag, act, exp);
        if (expect_first) begin
            check(warp_valid_o || done_o, "R2", {warp_valid_o, done_o}, 2'b11);
            expect_first = 0;
        end
        if (done_o && warp_valid_o) excl_err++;
        if (warp_valid_o && slot_vld_o == '0) excl_err++;
        if (done_o) dones_seen++;
        if (warp_valid_o) begin
            warps_seen++;
            for (int l = 0; l < LANES; l++) begin
                if (slot_vld_o[l]) begin
                    int id = int'(slot_tid_o[l*TIDW +: TIDW]);
                    if (id < THREADS) seen[id]++; else lane_err++;
                    if (id % LANES != l) lane_err++;
                end
            end
        end
    endtask

    task automatic step(input bit st, input logic [THREADS-1:0] m, input string tag);
        @(negedge clk);
        compare(tag);
        start_i = st;
        mask_i  = m;
        if (m_busy) begin
            if (q_vld.size() > 0) begin
                void'(q_vld.pop_front());
                void'(q_tid.pop_front());
            end else m_busy = 0;
        end else if (st) begin
            build(m);
            m_busy = 1;
            expect_first = 1;
        end
    endtask

    // one full run; intrude>0 pulses a foreign start on that busy cycle (R9)
    task automatic run(input logic [THREADS-1:0] m, input string tag, input int intrude);
        int maxc = 0, n = 0;
        for (int i = 0; i < THREADS; i++) seen[i] = 0;
        warps_seen = 0; dones_seen = 0; lane_err = 0; excl_err = 0;
        step(1'b1, m, tag);
        while (m_busy && n < 20) begin
            n++;
            if (n == intrude) step(1'b1, ~m, "R9");
            else              step(1'b0, '0, tag);
        end
        for (int l = 0; l < LANES; l++) begin
            int c = 0;
            for (int r = 0; r < ROWS; r++) c += int'(m[r*LANES + l]);
            if (c > maxc) maxc = c;
        end
        begin
            int bad = 0;
            for (int i = 0; i < THREADS; i++) if (seen[i] != int'(m[i])) bad++;
            check(bad == 0, "R5", bad, 0);
        end
        check(lane_err == 0, "R3", lane_err, 0);
        check(warps_seen == maxc && dones_seen == 1, "R6", {warps_seen, dones_seen}, {maxc, 1});
        check(excl_err == 0, "R10", excl_err, 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({busy_o, warp_valid_o, done_o, slot_vld_o, slot_tid_o} == 0, "R1",
              {busy_o, warp_valid_o, done_o, slot_vld_o, slot_tid_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy_o, warp_valid_o, done_o} == 0, "R1", {busy_o, warp_valid_o, done_o}, 0);

        run('0, "R7", 0);
        check(warps_seen == 0, "R7", warps_seen, 0);
        run('1, "R8", 0);
        run(12'b1100_1101_0011, "R4", 0);     // threads 0,1,4,6,7,10,11
        run(12'b0001_0001_0001, "R6", 2);     // one lane full; foreign start mid-run
        run(12'b0000_0000_1111, "R9", 2);     // foreign start on the done cycle
        for (int m = 0; m < (1 << THREADS); m++) begin
            run(THREADS'(m), "R5", 0);
        end
        step(1'b0, '0, "R1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule